// File: doc/BRIEF.md
# MOESI Line Coherence Controller

This block holds the coherence state and data of a small set of cache lines for one core's private cache. The core sends load, store and flush commands. The controller answers hits locally. On a miss, or on a store without write permission, it issues a request on a valid/ready channel toward the directory. It then waits for the response and stalls the core until that response arrives. Probes from the memory side can read or invalidate a line. The controller answers each probe one cycle later and supplies the line data when it holds the most recent copy.

Each line stores a 3-bit state: I=0, S=1, O=2, M=3 and MM=4. M means exclusive and clean. MM means exclusive and possibly dirty. While a transaction is open, the line involved carries a transient code: 5 for a read that is pending, 6 for a pending write permission, and 7 for a flush that is pending. A flush is a two-phase exchange. The controller first asks the directory to block the line. It then hands the data back with a release message. Only one transaction is open at a time.

Top module: `moesi_coh_ctrl`

## Requirements
- R1: After reset every line is I. core_ready is high, and req_valid, core_done and snp_ack are low.
- R2: A load (core_op=0) that hits a line in S, O, M or MM raises core_done in the cycle after acceptance, with the line data on core_rdata, and issues no request.
- R3: A load to an I line issues a request with req_type=0 (read) and req_idx equal to the line. When rsp_valid arrives, the line becomes M if rsp_shared=0 and S if rsp_shared=1. The line takes rsp_data, and core_done with that data follows one cycle later.
- R4: A store (core_op=1) to an M or MM line issues no request. It raises core_done in the next cycle, and the line becomes MM holding core_wdata.
- R5: A store to an I, S or O line issues req_type=1 (exclusive). On rsp_valid the line becomes MM holding the store data, and core_done follows one cycle later.
- R6: A flush (core_op=2) of a valid line issues req_type=2 (block) and waits for rsp_valid. It then issues req_type=3 (release) with the line data on req_data. The line ends in I, and core_done follows the release handshake by one cycle. A flush of an I line completes in the next cycle with no request.
- R7: A read probe (snp_inv=0) moves MM or M to O and leaves O and S unchanged. snp_supply is raised with the line data for MM, M and O, and not for S or I. snp_ack follows every probe by one cycle.
- R8: An invalidating probe (snp_inv=1) moves any stable valid line to I. Data is supplied only if the line was MM or O.
- R9: core_ready is low while a transaction is open and in any cycle where snp_valid is high. A command is accepted only when all lines are stable.
- R10: A probe to the line with an open transaction is acknowledged without data and does not change that line.
- R11: While req_valid is high and req_ready is low, req_valid, req_type and req_idx hold.
- R12: rsp_valid is ignored when no response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_valid | input | 1 | Core command valid |
| core_ready | output | 1 | Controller can accept a command |
| core_op | input | 2 | 0 load, 1 store, 2 flush, 3 no operation |
| core_idx | input | IDX_W | Line index of the command |
| core_wdata | input | DATA_W | Store data |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Load result, valid with core_done |
| req_valid | output | 1 | Outgoing request valid |
| req_ready | input | 1 | Request accepted by the directory |
| req_type | output | 2 | 0 read, 1 exclusive, 2 block, 3 release with data |
| req_idx | output | IDX_W | Line index of the request |
| req_data | output | DATA_W | Writeback data on a release |
| rsp_valid | input | 1 | Response or block acknowledgement |
| rsp_shared | input | 1 | Other sharers exist (read responses) |
| rsp_data | input | DATA_W | Fill data for a read response |
| snp_valid | input | 1 | Probe valid |
| snp_inv | input | 1 | 1 invalidate, 0 read |
| snp_idx | input | IDX_W | Probed line |
| snp_ack | output | 1 | Probe answered, one cycle after the probe |
| snp_supply | output | 1 | snp_data carries the line |
| snp_data | output | DATA_W | Probe data |

## Verification
A core command and a probe can land in the same cycle. The bench issues both at once from parallel tasks. It expects the command to wait exactly one cycle while the probe is answered and its state change lands first. A probe can also arrive while a transaction is open. The bench stretches the response delay and sends an invalidating probe to the pending line, plus a read probe to another line. The reference model then requires no data and no change for the pending line, and a normal answer for the other. Every output is compared against the model on every clock.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    ST_I       = 3'd0,
    ST_S       = 3'd1,
    ST_O       = 3'd2,
    ST_M       = 3'd3,
    ST_MM      = 3'd4,
    ST_RD_PEND = 3'd5,
    ST_WR_PEND = 3'd6,
    ST_FL_PEND = 3'd7
  } line_st_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FLUSH = 2'd2,
    OP_NOP   = 2'd3
  } core_op_e;

  typedef enum logic [1:0] {
    MSG_READ  = 2'd0,
    MSG_EXCL  = 2'd1,
    MSG_BLOCK = 2'd2,
    MSG_REL   = 2'd3
  } msg_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_WAIT = 2'd2,
    PH_WB   = 2'd3
  } phase_e;

  function automatic logic is_stable_valid(line_st_e s);
    return (s == ST_S) || (s == ST_O) || (s == ST_M) || (s == ST_MM);
  endfunction

endpackage

// File: rtl/moesi_line_slot.sv
module moesi_line_slot
  import moesi_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_hit,
  input  logic              probe_inv,
  input  logic              upd_en,
  input  line_st_e          upd_state,
  input  logic              upd_wr,
  input  logic [DATA_W-1:0] upd_data,
  output line_st_e          state_o,
  output logic [DATA_W-1:0] data_o
);

  line_st_e          st_q, st_d;
  logic [DATA_W-1:0] dat_q;
  logic              dat_en;

  always_comb begin
    st_d = st_q;
    if (upd_en) begin
      st_d = upd_state;
    end else if (probe_hit && is_stable_valid(st_q)) begin
      if (probe_inv) begin
        st_d = ST_I;
      end else if ((st_q == ST_MM) || (st_q == ST_M)) begin
        st_d = ST_O;
      end
    end
  end

  assign dat_en = upd_en && upd_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_I;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dat_en) begin
      dat_q <= upd_data;
    end
  end

  assign state_o = st_q;
  assign data_o  = dat_q;

  // R8: an invalidating probe on a stable valid line leaves it invalid
  p_inv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_hit && probe_inv && !upd_en && is_stable_valid(st_q)) |=> (st_q == ST_I));

  // R10: a probe to a line with an open transaction changes nothing
  p_pending_line_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_hit && !upd_en && !is_stable_valid(st_q) && (st_q != ST_I)) |=> $stable(st_q));

endmodule

// File: rtl/moesi_probe_reply.sv
module moesi_probe_reply
  import moesi_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic              snp_inv,
  input  line_st_e          line_state,
  input  logic [DATA_W-1:0] line_data,
  output logic              snp_ack,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);

  logic              ack_q, sup_q, sup_d;
  logic [DATA_W-1:0] dat_q;

  always_comb begin
    sup_d = 1'b0;
    if (snp_valid) begin
      unique case (line_state)
        ST_MM:   sup_d = 1'b1;
        ST_O:    sup_d = 1'b1;
        ST_M:    sup_d = !snp_inv;
        default: sup_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      sup_q <= 1'b0;
    end else begin
      ack_q <= snp_valid;
      sup_q <= sup_d;
    end
  end

  always_ff @(posedge clk) begin
    if (snp_valid) begin
      dat_q <= line_data;
    end
  end

  assign snp_ack    = ack_q;
  assign snp_supply = sup_q;
  assign snp_data   = dat_q;

  // R7: every answer follows a probe by exactly one cycle
  p_ack_after_probe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_ack |-> $past(snp_valid));

  // R7: data is only supplied together with an acknowledgement
  p_supply_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_ack);

endmodule

// File: rtl/moesi_txn_fsm.sv
module moesi_txn_fsm
  import moesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_valid,
  output logic              core_ready,
  input  logic [1:0]        core_op,
  input  logic [IDX_W-1:0]  core_idx,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  input  logic              snp_busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_type,
  output logic [IDX_W-1:0]  req_idx,
  output logic [DATA_W-1:0] req_data,
  input  logic              rsp_valid,
  input  logic              rsp_shared,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [IDX_W-1:0]  sel_idx,
  input  line_st_e          sel_state,
  input  logic [DATA_W-1:0] sel_data,
  output logic              upd_en,
  output line_st_e          upd_state,
  output logic              upd_wr,
  output logic [DATA_W-1:0] upd_data
);

  phase_e            phase_q, phase_d;
  msg_e              type_q, type_d;
  logic              done_q, done_d;
  logic [IDX_W-1:0]  idx_q;
  core_op_e          op_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  logic              accept;
  core_op_e          op_in;

  assign op_in      = core_op_e'(core_op);
  assign core_ready = (phase_q == PH_IDLE) && !snp_busy;
  assign accept     = core_valid && core_ready;

  always_comb begin
    phase_d   = phase_q;
    type_d    = type_q;
    done_d    = 1'b0;
    rdata_en  = 1'b0;
    rdata_d   = sel_data;
    upd_en    = 1'b0;
    upd_state = ST_I;
    upd_wr    = 1'b0;
    upd_data  = core_wdata;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          unique case (op_in)
            OP_LOAD: begin
              if (is_stable_valid(sel_state)) begin
                done_d   = 1'b1;
                rdata_en = 1'b1;
              end else begin
                upd_en    = 1'b1;
                upd_state = ST_RD_PEND;
                type_d    = MSG_READ;
                phase_d   = PH_REQ;
              end
            end
            OP_STORE: begin
              if ((sel_state == ST_MM) || (sel_state == ST_M)) begin
                upd_en    = 1'b1;
                upd_state = ST_MM;
                upd_wr    = 1'b1;
                done_d    = 1'b1;
              end else begin
                upd_en    = 1'b1;
                upd_state = ST_WR_PEND;
                type_d    = MSG_EXCL;
                phase_d   = PH_REQ;
              end
            end
            OP_FLUSH: begin
              if (sel_state == ST_I) begin
                done_d = 1'b1;
              end else begin
                upd_en    = 1'b1;
                upd_state = ST_FL_PEND;
                type_d    = MSG_BLOCK;
                phase_d   = PH_REQ;
              end
            end
            default: done_d = 1'b1;
          endcase
        end
      end
      PH_REQ: begin
        if (req_ready) begin
          phase_d = PH_WAIT;
        end
      end
      PH_WAIT: begin
        if (rsp_valid) begin
          unique case (op_q)
            OP_LOAD: begin
              upd_en    = 1'b1;
              upd_state = rsp_shared ? ST_S : ST_M;
              upd_wr    = 1'b1;
              upd_data  = rsp_data;
              rdata_en  = 1'b1;
              rdata_d   = rsp_data;
              done_d    = 1'b1;
              phase_d   = PH_IDLE;
            end
            OP_STORE: begin
              upd_en    = 1'b1;
              upd_state = ST_MM;
              upd_wr    = 1'b1;
              upd_data  = wd_q;
              done_d    = 1'b1;
              phase_d   = PH_IDLE;
            end
            default: begin
              type_d  = MSG_REL;
              phase_d = PH_WB;
            end
          endcase
        end
      end
      PH_WB: begin
        if (req_ready) begin
          upd_en    = 1'b1;
          upd_state = ST_I;
          done_d    = 1'b1;
          phase_d   = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      type_q  <= MSG_READ;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      type_q  <= type_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      idx_q <= core_idx;
      op_q  <= op_in;
      wd_q  <= core_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign sel_idx    = (phase_q == PH_IDLE) ? core_idx : idx_q;
  assign req_valid  = (phase_q == PH_REQ) || (phase_q == PH_WB);
  assign req_type   = type_q;
  assign req_idx    = idx_q;
  assign req_data   = sel_data;
  assign core_done  = done_q;
  assign core_rdata = rdata_q;

  // R9: after an accepted command either it completes or the core is held off
  p_single_txn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_ready) |=> (core_done || !core_ready));

  // R11: a request that is not taken stays put
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_type) && $stable(req_idx)));

  // R6: the release message only starts after the block acknowledgement
  p_release_after_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && (req_type == MSG_REL)) |-> $past(rsp_valid));

  // R4: a store with write permission completes locally
  p_store_hit_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op_in == OP_STORE) && ((sel_state == ST_MM) || (sel_state == ST_M)))
      |=> (!req_valid && core_done));

endmodule

// File: rtl/moesi_coh_ctrl.sv
module moesi_coh_ctrl
  import moesi_pkg::*;
#(
  parameter  int NUM_LINES = 4,
  parameter  int DATA_W    = 32,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_valid,
  output logic              core_ready,
  input  logic [1:0]        core_op,
  input  logic [IDX_W-1:0]  core_idx,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_type,
  output logic [IDX_W-1:0]  req_idx,
  output logic [DATA_W-1:0] req_data,
  input  logic              rsp_valid,
  input  logic              rsp_shared,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              snp_valid,
  input  logic              snp_inv,
  input  logic [IDX_W-1:0]  snp_idx,
  output logic              snp_ack,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);

  line_st_e          st_arr  [NUM_LINES];
  logic [DATA_W-1:0] dat_arr [NUM_LINES];

  logic [IDX_W-1:0]  sel_idx;
  line_st_e          sel_state;
  logic [DATA_W-1:0] sel_data;
  logic              upd_en;
  line_st_e          upd_state;
  logic              upd_wr;
  logic [DATA_W-1:0] upd_data;
  line_st_e          prb_state;
  logic [DATA_W-1:0] prb_data;

  assign sel_state = st_arr[sel_idx];
  assign sel_data  = dat_arr[sel_idx];
  assign prb_state = st_arr[snp_idx];
  assign prb_data  = dat_arr[snp_idx];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit_g, upd_g;
    assign hit_g = snp_valid && (snp_idx == IDX_W'(g));
    assign upd_g = upd_en && (sel_idx == IDX_W'(g));

    moesi_line_slot #(.DATA_W(DATA_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .probe_hit (hit_g),
      .probe_inv (snp_inv),
      .upd_en    (upd_g),
      .upd_state (upd_state),
      .upd_wr    (upd_wr),
      .upd_data  (upd_data),
      .state_o   (st_arr[g]),
      .data_o    (dat_arr[g])
    );
  end

  moesi_txn_fsm #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_valid (core_valid),
    .core_ready (core_ready),
    .core_op    (core_op),
    .core_idx   (core_idx),
    .core_wdata (core_wdata),
    .core_done  (core_done),
    .core_rdata (core_rdata),
    .snp_busy   (snp_valid),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_type   (req_type),
    .req_idx    (req_idx),
    .req_data   (req_data),
    .rsp_valid  (rsp_valid),
    .rsp_shared (rsp_shared),
    .rsp_data   (rsp_data),
    .sel_idx    (sel_idx),
    .sel_state  (sel_state),
    .sel_data   (sel_data),
    .upd_en     (upd_en),
    .upd_state  (upd_state),
    .upd_wr     (upd_wr),
    .upd_data   (upd_data)
  );

  moesi_probe_reply #(.DATA_W(DATA_W)) u_prb (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_valid  (snp_valid),
    .snp_inv    (snp_inv),
    .line_state (prb_state),
    .line_data  (prb_data),
    .snp_ack    (snp_ack),
    .snp_supply (snp_supply),
    .snp_data   (snp_data)
  );

  // R9: no command is taken in a cycle that carries a probe
  p_probe_blocks_core_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !core_ready);

endmodule

// File: tb/moesi_coh_ctrl_test.sv
module moesi_coh_ctrl_test;
  localparam int NL = 4;
  localparam int DW = 32;
  localparam int IW = 2;

  logic          clk;
  logic          rst_n;
  logic          core_valid, core_ready, core_done;
  logic [1:0]    core_op;
  logic [IW-1:0] core_idx;
  logic [DW-1:0] core_wdata, core_rdata;
  logic          req_valid, req_ready;
  logic [1:0]    req_type;
  logic [IW-1:0] req_idx;
  logic [DW-1:0] req_data;
  logic          rsp_valid, rsp_shared;
  logic [DW-1:0] rsp_data;
  logic          snp_valid, snp_inv, snp_ack, snp_supply;
  logic [IW-1:0] snp_idx;
  logic [DW-1:0] snp_data;

  moesi_coh_ctrl #(.NUM_LINES(NL), .DATA_W(DW)) uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    tests = 0;
  int    fails = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          ms [NL];
  logic [31:0] md [NL];
  int          mph = 0;
  int          mop = 0;
  int          midx = 0;
  int          mtype = 0;
  logic [31:0] mwd, mrdata, msdata;
  bit          mdone = 0, mack = 0, msup = 0, m_acc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (ms[k]) ms[k] = 0;
      mph = 0; mtype = 0; mdone = 0; mack = 0; msup = 0; m_acc = 0;
    end else begin
      bit rdy;
      int s;
      rdy   = (mph == 0) && !snp_valid;
      m_acc = 0; mdone = 0; mack = 0; msup = 0;
      if (snp_valid) begin
        s      = ms[snp_idx];
        mack   = 1;
        msdata = md[snp_idx];
        if (s >= 1 && s <= 4) begin
          if (snp_inv) begin
            msup = (s == 4 || s == 2);
            ms[snp_idx] = 0;
          end else begin
            msup = (s == 4 || s == 3 || s == 2);
            if (s == 4 || s == 3) ms[snp_idx] = 2;
          end
        end
      end
      case (mph)
        0: if (core_valid && rdy) begin
          m_acc = 1; midx = core_idx; mop = core_op; mwd = core_wdata;
          s = ms[midx];
          case (mop)
            0: if (s != 0) begin mdone = 1; mrdata = md[midx]; end
               else begin ms[midx] = 5; mtype = 0; mph = 1; end
            1: if (s == 4 || s == 3) begin ms[midx] = 4; md[midx] = mwd; mdone = 1; end
               else begin ms[midx] = 6; mtype = 1; mph = 1; end
            2: if (s == 0) mdone = 1;
               else begin ms[midx] = 7; mtype = 2; mph = 1; end
            default: mdone = 1;
          endcase
        end
        1: if (req_ready) mph = 2;
        2: if (rsp_valid) begin
          if (mop == 0) begin
            ms[midx] = rsp_shared ? 1 : 3; md[midx] = rsp_data; mrdata = rsp_data;
            mdone = 1; mph = 0;
          end else if (mop == 1) begin
            ms[midx] = 4; md[midx] = mwd; mdone = 1; mph = 0;
          end else begin
            mph = 3; mtype = 3;
          end
        end
        default: if (req_ready) begin ms[midx] = 0; mdone = 1; mph = 0; end
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      ev = (mph == 1 || mph == 3);
      chk(core_ready == ((mph == 0) && !snp_valid), "core_ready", 64'(core_ready), 64'((mph == 0) && !snp_valid));
      chk(core_done == mdone, "core_done", 64'(core_done), 64'(mdone));
      if (mdone && mop == 0) chk(core_rdata == mrdata, "core_rdata", 64'(core_rdata), 64'(mrdata));
      chk(req_valid == ev, "req_valid", 64'(req_valid), 64'(ev));
      if (ev) begin
        chk(req_type == 2'(mtype), "req_type", 64'(req_type), 64'(mtype));
        chk(req_idx == IW'(midx), "req_idx", 64'(req_idx), 64'(midx));
        if (mph == 3) chk(req_data == md[midx], "req_data", 64'(req_data), 64'(md[midx]));
      end
      chk(snp_ack == mack, "snp_ack", 64'(snp_ack), 64'(mack));
      chk(snp_supply == msup, "snp_supply", 64'(snp_supply), 64'(msup));
      if (msup) chk(snp_data == msdata, "snp_data", 64'(snp_data), 64'(msdata));
    end
  end

  // ---------------- directory responder ----------------
  int       rsp_delay = 1;
  bit       rsp_sh = 0;
  bit [3:0] rdy_pat = 4'hF;
  int       pend = 0;
  int       cyc = 0;
  bit       stray = 0;

  always @(negedge clk) begin
    #1;
    rsp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        rsp_valid  = 1'b1;
        rsp_shared = rsp_sh;
        rsp_data   = 32'hA500_0000 + 32'(cyc);
      end
    end
    if (stray) begin
      rsp_valid  = 1'b1;
      rsp_shared = 1'b1;
      rsp_data   = 32'hDEAD_0000 + 32'(cyc);
      stray      = 0;
    end
    cyc++;
    req_ready = rdy_pat[cyc % 4];
    if (rst_n && req_valid && req_ready && (req_type != 2'd3)) pend = rsp_delay;
  end

  // ---------------- stimulus tasks ----------------
  task automatic core_cmd(input int op, input int idx, input logic [31:0] wd);
    @(negedge clk); #2;
    core_valid = 1'b1; core_op = 2'(op); core_idx = IW'(idx); core_wdata = wd;
    do @(negedge clk); while (!m_acc);
    #2 core_valid = 1'b0;
  endtask

  task automatic probe(input bit inv, input int idx);
    @(negedge clk); #2;
    snp_valid = 1'b1; snp_inv = inv; snp_idx = IW'(idx);
    @(negedge clk); #2;
    snp_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (mph != 0 || core_valid);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; core_valid = 1'b0; core_op = 2'd0; core_idx = '0; core_wdata = '0;
    req_ready = 1'b1; rsp_valid = 1'b0; rsp_shared = 1'b0; rsp_data = '0;
    snp_valid = 1'b0; snp_inv = 1'b0; snp_idx = '0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    cur_req = "R1";
    chk(core_ready == 1'b1, "reset core_ready", 64'(core_ready), 64'd1);
    chk(req_valid == 1'b0, "reset req_valid", 64'(req_valid), 64'd0);
    chk(snp_ack == 1'b0, "reset snp_ack", 64'(snp_ack), 64'd0);
    chk(core_done == 1'b0, "reset core_done", 64'(core_done), 64'd0);

    // R3: read miss, no sharers -> M
    cur_req = "R3"; rsp_sh = 0; rsp_delay = 2;
    core_cmd(0, 0, 0); wait_idle();
    // R2: read hit
    cur_req = "R2"; core_cmd(0, 0, 0); wait_idle();
    // R4: store in M then in MM, both local
    cur_req = "R4";
    core_cmd(1, 0, 32'h1111_0001); wait_idle();
    core_cmd(1, 0, 32'h2222_0002); wait_idle();
    cur_req = "R2"; core_cmd(0, 0, 0); wait_idle();
    // R3: read miss with sharers -> S
    cur_req = "R3"; rsp_sh = 1; rsp_delay = 1;
    core_cmd(0, 1, 0); wait_idle();
    // R5 and R11: exclusive request with a slow directory
    cur_req = "R11"; rdy_pat = 4'b1000;
    core_cmd(1, 1, 32'h3333_0003); wait_idle();
    rdy_pat = 4'hF;
    // R7: read probes on MM and O
    cur_req = "R7";
    probe(0, 0); probe(0, 0);
    core_cmd(0, 0, 0); wait_idle();
    probe(0, 1);
    // R5: store to an owned line
    cur_req = "R5"; core_cmd(1, 0, 32'h4444_0004); wait_idle();
    // R8: invalidate an owned line, then probe it as I
    cur_req = "R8"; probe(1, 1);
    cur_req = "R7"; probe(0, 1);
    cur_req = "R3"; rsp_sh = 1; core_cmd(0, 2, 0); wait_idle();
    cur_req = "R7"; probe(0, 2);
    cur_req = "R8"; probe(1, 2);
    // R6: flush a dirty line, then an invalid one, then refetch
    cur_req = "R6"; rsp_delay = 3;
    core_cmd(2, 0, 0); wait_idle();
    core_cmd(2, 3, 0); wait_idle();
    rsp_sh = 0; rsp_delay = 1;
    core_cmd(0, 0, 0); wait_idle();
    // R9: command and probe in the same cycle
    cur_req = "R9";
    fork
      core_cmd(0, 2, 0);
      probe(0, 0);
    join
    wait_idle();
    // R10: probes while a transaction is open
    cur_req = "R10"; rsp_delay = 6;
    fork
      core_cmd(1, 3, 32'h5555_0005);
      begin
        repeat (3) @(negedge clk);
        probe(1, 3);
        probe(0, 0);
      end
    join
    wait_idle();
    rsp_delay = 1;
    core_cmd(0, 3, 0); wait_idle();
    // R12: stray response while idle
    cur_req = "R12";
    @(negedge clk); stray = 1;
    repeat (3) @(negedge clk);
    core_cmd(0, 3, 0); wait_idle();
    core_cmd(0, 1, 0); wait_idle();
    // R6 and R11: flush with a slow directory
    cur_req = "R6"; rdy_pat = 4'b0010;
    core_cmd(2, 3, 0); wait_idle();
    rdy_pat = 4'hF;
    core_cmd(0, 3, 0); wait_idle();
    finish_run();
  end

endmodule